// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is a slave on an open-drain two-wire serial bus, of the kind used for on-board configuration. Through the bus it gives access to a 256-entry register file that lives outside the block. A fast system clock oversamples both bus lines, each through a two-flop synchronizer. START and STOP conditions, and the edges of the serial clock, are derived from those synchronized copies. The block never drives a line high. It only asserts a pull-down enable for the data line, and the pad or the bench turns that enable into a wired-AND.

A master reaches the registers in two ways:
- **Writing.** It addresses the device with the write bit. The next byte is taken as the register pointer, and every further byte is stored at the pointer, which then advances.
- **Reading.** It addresses the device with the read bit. The slave then streams bytes starting at the current pointer. A random read is therefore a write that carries only the pointer byte, followed by a repeated START and the address byte with the read bit set.

The pointer keeps its value between transactions. It wraps from 255 to 0.

The 7-bit device address comes from an input port or from a parameter, selected by a parameter. This lets several instances share the same two wires.

Top module: `twr_slave`

## Requirements
- R1: After synchronous reset the data-line pull-down is released, the register pointer (`reg_rd_addr`) is 0 and no register write is issued.
- R2: A falling data line while the clock line is high is a START. A rising data line while the clock line is high is a STOP. Either releases the data line. After a START the next byte is always taken as an address byte, even in the middle of ignored traffic. After a STOP the block stays idle.
- R3: After a START, bits 7..1 of the first byte (sent MSB first) are the device address and bit 0 is the direction (1 = read, 0 = write). On a match the slave holds the data line low (ACK) for the whole ninth clock.
- R4: On an address mismatch the slave gives no ACK. It then ignores all traffic until the next START or STOP: it issues no register write, does not change the pointer and does not drive the data line.
- R5: In a write transaction the first byte after the address byte is loaded into the register pointer and acknowledged. It is not written to any register.
- R6: Each further byte in a write transaction is acknowledged and written to the register at the pointer, with a one-cycle `reg_wr_en` pulse. The pointer then advances by one.
- R7: A read transaction sends the byte at the current pointer, MSB first. A zero-data write of the pointer, then a repeated START, then the address with the read bit set therefore returns the register just selected.
- R8: During a read, a master ACK (data line low in the ninth clock) advances the pointer, and the next byte is sent. A master NACK ends the output: the slave releases the data line and the pointer stays on the last byte sent.
- R9: The pointer wraps from 255 to 0 on both writes and reads.
- R10: The slave changes its pull-down only while the clock line is low.
- R11: With `ADDR_FROM_PORT = 1` the address compared is `dev_addr`, and a change of that input takes effect from the next address byte. With `ADDR_FROM_PORT = 0` the address is `FIXED_ADDR`. Two instances on the same wires answer only their own addresses.
- R12: The pointer persists across STOP. A read transaction with no preceding pointer write starts at the pointer left by the previous transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the pad |
| sda_in | input | 1 | Data line as seen on the pad (wired-AND of all drivers) |
| sda_pull | output | 1 | Pull-down enable for the data line (1 = drive low) |
| dev_addr | input | 7 | Device address used when `ADDR_FROM_PORT = 1` |
| reg_rd_addr | output | 8 | Register pointer; address for the register-file read |
| reg_rd_data | input | 8 | Register-file read data for `reg_rd_addr` (combinational) |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register write address |
| reg_wr_data | output | 8 | Register write data |

## Verification
Two things can fall in the same clock cycle: the register write for an accepted byte and the pointer advance it causes. These share one edge, and the write must use the old pointer. The bench provokes this with multi-byte writes that start at 0xFE and at random pointers, so the run crosses the 255-to-0 wrap. It judges the result by the register contents and by the pointer seen on `reg_rd_addr`. The other pair is a START that arrives while the slave is ignoring a mismatched transaction. The bench provokes it with a repeated START right after a foreign address and checks that the very next address byte is acknowledged.

// File: rtl/twr_pkg.sv
package twr_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR7_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_PTR,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } twr_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } twr_ev_t;

    // Compare the upper seven bits of a received address byte with the device address.
    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [ADDR7_W-1:0] a);
        return (b >> 1) == {1'b0, a};
    endfunction

endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    // Idle bus level is high, so the chain resets to ones.
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/twr_cond.sv
module twr_cond
    import twr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sda_s,
    input  logic    scl_s,
    output twr_ev_t ev
);
    logic sda_q, scl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
        end else begin
            sda_q <= sda_s;
            scl_q <= scl_s;
        end
    end

    always_comb begin
        ev.start    = sda_q & ~sda_s & scl_q & scl_s;
        ev.stop     = ~sda_q & sda_s & scl_q & scl_s;
        ev.scl_rise = ~scl_q & scl_s;
        ev.scl_fall = scl_q & ~scl_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/twr_engine.sv
module twr_engine
    import twr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  twr_ev_t            ev,
    input  logic [ADDR7_W-1:0] my_addr,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_pull,
    output logic [BYTE_W-1:0]  rd_addr,
    output logic               wr_en,
    output logic [BYTE_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0]  wr_data
);
    localparam int               CNT_W = $clog2(BYTE_W) + 1;
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(BYTE_W);

    twr_state_e          state;
    logic [CNT_W-1:0]    cnt;
    logic [BYTE_W-1:0]   sh;
    logic [BYTE_W-1:0]   tx;
    logic [BYTE_W-1:0]   ptr;
    logic                in_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '0;
            ptr     <= '0;
            in_ack  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                state  <= ST_DEVADR;
                cnt    <= '0;
                in_ack <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                in_ack <= 1'b0;
            end else if (in_ack) begin
                // ACK clock owned by the slave ends on the next falling edge.
                if (ev.scl_fall) begin
                    in_ack <= 1'b0;
                    cnt    <= '0;
                    if (state == ST_RDATA) tx <= rd_data;
                end
            end else begin
                case (state)
                    ST_DEVADR, ST_PTR, ST_WDATA: begin
                        if (ev.scl_rise && cnt != FULL) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == FULL) begin
                            if (state == ST_DEVADR) begin
                                if (addr_hit(sh, my_addr)) begin
                                    in_ack <= 1'b1;
                                    state  <= sh[0] ? ST_RDATA : ST_PTR;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_PTR) begin
                                ptr    <= sh;
                                in_ack <= 1'b1;
                                state  <= ST_WDATA;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= sh;
                                ptr     <= ptr + 1'b1;
                                in_ack  <= 1'b1;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (cnt == FULL)   state <= ST_RACK;
                            else if (cnt != '0) tx   <= {tx[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            if (ev.sda) state <= ST_SKIP;
                            else        ptr   <= ptr + 1'b1;
                        end else if (ev.scl_fall) begin
                            tx    <= rd_data;
                            cnt   <= '0;
                            state <= ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = in_ack | ((state == ST_RDATA) & ~tx[BYTE_W-1]);
    assign rd_addr  = ptr;
endmodule

// File: rtl/twr_slave.sv
module twr_slave
    import twr_pkg::*;
#(
    parameter int                SYNC_STAGES    = 2,
    parameter bit                ADDR_FROM_PORT = 1'b1,
    parameter logic [ADDR7_W-1:0] FIXED_ADDR    = 7'h50
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic [ADDR7_W-1:0] dev_addr,
    output logic [BYTE_W-1:0]  reg_rd_addr,
    input  logic [BYTE_W-1:0]  reg_rd_data,
    output logic               reg_wr_en,
    output logic [BYTE_W-1:0]  reg_wr_addr,
    output logic [BYTE_W-1:0]  reg_wr_data
);
    logic               scl_s, sda_s;
    twr_ev_t            bus_ev;
    logic [ADDR7_W-1:0] match_addr;

    twr_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst(rst), .din(scl_in), .dout(scl_s)
    );
    twr_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst(rst), .din(sda_in), .dout(sda_s)
    );

    twr_cond u_cond (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_s(scl_s), .ev(bus_ev)
    );

    generate
        if (ADDR_FROM_PORT) begin : g_port_addr
            assign match_addr = dev_addr;
        end else begin : g_fixed_addr
            assign match_addr = FIXED_ADDR;
        end
    endgenerate

    twr_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (bus_ev),
        .my_addr  (match_addr),
        .rd_data  (reg_rd_data),
        .sda_pull (sda_pull),
        .rd_addr  (reg_rd_addr),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data)
    );
endmodule

// File: rtl/twr_slave_chk.sv
module twr_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       scl_fall,
    input logic       sda_pull,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] rd_addr
);
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !scl_s);                                  // R10

    AST_START_RELEASE: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_pull);                                        // R2

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_pull);                                         // R2

    AST_WR_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(scl_fall));                                      // R6

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);                                               // R6

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> rd_addr == wr_addr + 8'd1);                            // R9
endmodule

bind twr_slave twr_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .start_det (bus_ev.start),
    .stop_det  (bus_ev.stop),
    .scl_fall  (bus_ev.scl_fall),
    .sda_pull  (sda_pull),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .rd_addr   (reg_rd_addr)
);

// File: tb/twr_slave_tb.sv
module twr_slave_tb;
    localparam int Q = 8;  // quarter of a serial bit, in system clocks

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;  // 250 MHz

    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [6:0] dev_addr = 7'h50;

    logic       pull_a, pull_b;
    logic       sda_line;
    assign sda_line = m_sda & ~pull_a & ~pull_b;

    logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
    logic       wr_en;
    logic [7:0] fx_rd_addr, fx_wr_addr, fx_wr_data;
    logic       fx_wr_en;

    twr_slave u_dut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .sda_pull(pull_a),
        .dev_addr(dev_addr), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
        .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data)
    );

    twr_slave #(.ADDR_FROM_PORT(1'b0), .FIXED_ADDR(7'h2A)) u_fix (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .sda_pull(pull_b),
        .dev_addr(7'h00), .reg_rd_addr(fx_rd_addr), .reg_rd_data(~fx_rd_addr),
        .reg_wr_en(fx_wr_en), .reg_wr_addr(fx_wr_addr), .reg_wr_data(fx_wr_data)
    );

    // Register file attached to the main slave.
    logic [7:0] mem [256];
    assign rd_data = mem[rd_addr];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    logic [15:0] fx_last;
    int          wr_cnt = 0;
    always @(posedge clk) begin
        if (rst) fx_last <= '0;
        else if (fx_wr_en) fx_last <= {fx_wr_addr, fx_wr_data};
        if (!rst && wr_en) wr_cnt++;
    end

    // Counts pull-down changes seen while the clock line is high.
    int   pull_viol = 0;
    logic pull_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && (pull_a !== pull_prev) && m_scl) pull_viol++;
        pull_prev <= pull_a;
    end

    int total = 0;
    int fails = 0;
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr = 8'h00;
    logic [7:0] wbuf [8];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wq(); wq();
            m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        ack = !sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1; wq();
            b[i] = sda_line; wq();
            m_scl = 1'b0;
        end
        wq();
        m_sda = give_ack ? 1'b0 : 1'b1; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] p, input int n);
        bit ack;
        bus_start();
        send_byte({a, 1'b0}, ack); chk("R3 write address ACK", 32'(ack), 1);
        send_byte(p, ack);         chk("R5 pointer byte ACK", 32'(ack), 1);
        exp_ptr = p;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack); chk("R6 data byte ACK", 32'(ack), 1);
            exp_mem[exp_ptr] = wbuf[i];
            exp_ptr = exp_ptr + 8'd1;
        end
        bus_stop();
        for (int i = 0; i < n; i++)
            chk("R6 register content", 32'(mem[8'(p + 8'(i))]), 32'(wbuf[i]));
        chk("R6 R9 pointer after write", 32'(rd_addr), 32'(exp_ptr));
    endtask

    task automatic read_body(input int n);
        logic [7:0] got;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, got);
            chk("R7 R8 read byte", 32'(got), 32'(exp_mem[exp_ptr]));
            if (i < n - 1) exp_ptr = exp_ptr + 8'd1;
        end
        bus_stop();
        chk("R8 pointer after NACK", 32'(rd_addr), 32'(exp_ptr));
        chk("R8 released after NACK", 32'(pull_a), 0);
    endtask

    task automatic do_rread(input logic [6:0] a, input logic [7:0] p, input int n);
        bit ack;
        bus_start();
        send_byte({a, 1'b0}, ack); chk("R3 address ACK", 32'(ack), 1);
        send_byte(p, ack);         chk("R5 pointer ACK", 32'(ack), 1);
        exp_ptr = p;
        bus_start();
        send_byte({a, 1'b1}, ack); chk("R7 read address ACK", 32'(ack), 1);
        read_body(n);
    endtask

    task automatic do_cread(input logic [6:0] a, input int n);
        bit ack;
        bus_start();
        send_byte({a, 1'b1}, ack); chk("R12 read address ACK", 32'(ack), 1);
        read_body(n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        bit         ack;
        int         snap;
        logic [7:0] p;
        int         n;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 7 + 3);

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 pull released", 32'(pull_a), 0);
        chk("R1 pointer zero", 32'(rd_addr), 0);
        chk("R1 no write", 32'(wr_cnt), 0);

        // Basic write, random read, then a read at the current pointer.
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(7'h50, 8'h10, 3);
        do_rread(7'h50, 8'h10, 3);
        do_cread(7'h50, 1);   // R12

        // Wrap on write and on read.
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        do_write(7'h50, 8'hFE, 3);
        chk("R9 wrapped pointer", 32'(rd_addr), 32'h01);
        do_rread(7'h50, 8'hFF, 2);

        // Foreign address is ignored.
        snap = wr_cnt;
        p = rd_addr;
        bus_start();
        send_byte({7'h51, 1'b0}, ack); chk("R4 no ACK on mismatch", 32'(ack), 0);
        send_byte(8'h20, ack);         chk("R4 no ACK on ignored byte", 32'(ack), 0);
        send_byte(8'h99, ack);         chk("R4 no ACK on ignored data", 32'(ack), 0);
        bus_stop();
        chk("R4 no write on mismatch", 32'(wr_cnt), 32'(snap));
        chk("R4 pointer untouched", 32'(rd_addr), 32'(p));

        // Repeated START during ignored traffic restarts address matching.
        bus_start();
        send_byte({7'h33, 1'b0}, ack); chk("R4 foreign address ignored", 32'(ack), 0);
        bus_start();
        send_byte({7'h50, 1'b0}, ack); chk("R2 address after restart", 32'(ack), 1);
        send_byte(8'h40, ack);
        send_byte(8'h5A, ack);         chk("R2 data after restart", 32'(ack), 1);
        bus_stop();
        exp_mem[8'h40] = 8'h5A;
        chk("R2 write after restart", 32'(mem[8'h40]), 32'h5A);

        // STOP right after the pointer byte: pointer set, nothing written.
        snap = wr_cnt;
        bus_start();
        send_byte({7'h50, 1'b0}, ack);
        send_byte(8'h41, ack);
        bus_stop();
        chk("R2 pull released after STOP", 32'(pull_a), 0);
        chk("R5 pointer loaded", 32'(rd_addr), 32'h41);
        chk("R5 pointer byte not written", 32'(wr_cnt), 32'(snap));
        exp_ptr = 8'h41;

        // Second slave on the same wires with a fixed address.
        snap = wr_cnt;
        bus_start();
        send_byte({7'h2A, 1'b0}, ack); chk("R11 fixed address ACK", 32'(ack), 1);
        send_byte(8'h10, ack);
        send_byte(8'h77, ack);         chk("R11 fixed data ACK", 32'(ack), 1);
        bus_stop();
        chk("R11 fixed slave write", 32'(fx_last), 32'h1077);
        chk("R11 main slave silent", 32'(wr_cnt), 32'(snap));
        begin
            logic [7:0] got;
            bus_start();
            send_byte({7'h2A, 1'b1}, ack);
            recv_byte(1'b0, got);
            bus_stop();
            chk("R11 fixed slave read", 32'(got), 32'hEE);
        end

        // Address taken from the port changes at run time.
        dev_addr = 7'h1C;
        bus_start();
        send_byte({7'h50, 1'b0}, ack); chk("R11 old address ignored", 32'(ack), 0);
        bus_stop();
        wbuf[0] = 8'h6D;
        do_write(7'h1C, 8'h80, 1);

        // Random write/read-back rounds.
        for (int r = 0; r < 8; r++) begin
            p = 8'($urandom);
            if (r == 0) p = 8'hFD;
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(7'h1C, p, n);
            do_rread(7'h1C, p, n);
        end

        chk("R10 pull changes only with clock low", 32'(pull_viol), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule